// File: doc/BRIEF.md
# Ones-Complement Frame Checksum Unit

This block computes a 16-bit ones'-complement checksum over a frame that arrives as a stream of words, one word per clock. A running sum restarts at zero on the first word of each frame. Each addition is folded back to 16 bits by adding any carry out of the top bit into the lowest bit in the same cycle. When the last word of the frame is taken, the block presents the bitwise inverse of the folded sum as the check value and raises a one-cycle strobe.

A sender uses the check value as the word it appends to the frame. A receiver streams the whole frame, including that appended word, with the check mode input high. The frame then verifies when the folded sum of all its words is all ones, which the block reports on a verified flag alongside the strobe. Header words are summed like any other word. Packing bytes into words is left to the logic upstream.

Top module: `ocsum_frame_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears sum_valid, sum_ok and sum_word to zero.
- R2: A word taken with frame_first high starts a new sum from zero, so words taken before it (an unfinished frame included) do not affect the result.
- R3: A carry out of bit 15 of an addition is added back into bit 0 (end-around carry), for example 0xFFFF followed by 0x0001 sums to 0x0001 and yields check value 0xFFFE.
- R4: One word is taken on every clock edge where word_valid is high; while word_valid is low, word_in, frame_first, frame_last and check_mode are all ignored.
- R5: sum_valid is high for exactly one cycle, the cycle after a word with frame_last high is taken, and sum_word then equals the bitwise inverse of the folded sum of every word of the frame, its first word included.
- R6: sum_word keeps its value until the next frame end is taken.
- R7: check_mode is sampled with the last word (1 = check, 0 = generate); in check mode sum_ok is 1 exactly when the folded sum of the frame is 0xFFFF (sum_word is then 0x0000), and in generate mode sum_ok is 0.
- R8: A frame made only of zero words never verifies; in generate mode its check value is 0xFFFF.
- R9: A frame of single words starting and ending on the same word (frame_first and frame_last both high) is summed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | 16 | Frame data word |
| word_valid | input | 1 | word_in and the markers are taken this cycle |
| frame_first | input | 1 | This word opens a frame |
| frame_last | input | 1 | This word closes a frame |
| check_mode | input | 1 | 1 = verify a frame that carries its check word, 0 = generate |
| sum_word | output | 16 | Inverted folded sum of the last finished frame |
| sum_valid | output | 1 | One-cycle strobe after a frame end |
| sum_ok | output | 1 | Frame verified (check mode only) |

## Verification
Single-word frames are swept across a stride of the whole word range, which shows the plain inversion and the all-zero and all-ones words. A grid of two-word frames covers pairs with and without a carry out of the top bit, separating an end-around fold from a plain modular sum. Longer frames are run back to back, with idle cycles carrying stray markers and an abandoned frame cut off by a new start, to tell apart correct restart and ignored input from leaked state. Check-mode runs append the generated word and then corrupt one word, distinguishing a true verify from a flag stuck high or low.

// File: rtl/ocsum_pkg.sv
// Package: shared types for the ones'-complement frame checksum unit.
// Assumes nothing beyond standard SystemVerilog.
package ocsum_pkg;
    // What the unit does with a finished frame.
    typedef enum logic {
        SUM_GENERATE = 1'b0,
        SUM_CHECK    = 1'b1
    } sum_mode_e;
endpackage

// File: rtl/ocsum_fold_add.sv
// Module: ocsum_fold_add
// Purely combinational ones'-complement adder: adds two W-bit words and
// feeds the carry out of the top bit back into bit 0.
// Assumes both operands are already folded to W bits; a single fold then
// cannot carry again, since the largest raw sum is 2^(W+1)-2.
module ocsum_fold_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W:0] raw;

    // Raw sum with one extra bit, then end-around fold of the carry.
    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        y   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end
endmodule

// File: rtl/ocsum_accum.sv
// Module: ocsum_accum
// Running sum register. On a taken word it stores the folded sum of the
// word and either the stored sum or zero (when the word opens a frame).
// sum_now shows the sum including the current word for the report stage.
// Assumes take is only high for valid words.
module ocsum_accum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         restart,
    input  logic [W-1:0] word,
    output logic [W-1:0] sum_now
);
    logic [W-1:0] acc_q;
    logic [W-1:0] base;

    // Pick the left operand: zero when a frame opens.
    always_comb begin
        base = restart ? '0 : acc_q;
    end

    ocsum_fold_add #(.W(W)) u_add (
        .a (base),
        .b (word),
        .y (sum_now)
    );

    // Hold the running sum; update only on a taken word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (take) begin
            acc_q <= sum_now;
        end
    end
endmodule

// File: rtl/ocsum_report.sv
// Module: ocsum_report
// Output stage: on the closing word it registers the inverted sum,
// a one-cycle strobe and the verify flag. Outputs hold between frames.
// Assumes close is high only in the cycle the last word is taken.
module ocsum_report #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                close,
    input  ocsum_pkg::sum_mode_e mode,
    input  logic [W-1:0]        sum_now,
    output logic [W-1:0]        sum_word,
    output logic                sum_valid,
    output logic                sum_ok
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic pass;

    // A carried check word brings the folded sum to all ones.
    always_comb begin
        pass = (mode == ocsum_pkg::SUM_CHECK) && (sum_now == ALL_ONES);
    end

    // Register result and strobe at frame end; keep the result otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_word  <= '0;
            sum_valid <= 1'b0;
            sum_ok    <= 1'b0;
        end else begin
            sum_valid <= close;
            if (close) begin
                sum_word <= ~sum_now;
                sum_ok   <= pass;
            end
        end
    end
endmodule

// File: rtl/ocsum_frame_unit.sv
// Module: ocsum_frame_unit (top)
// Streams a frame of 16-bit words and produces the inverted ones'-complement
// sum one cycle after the last word; in check mode it flags a frame whose
// sum, check word included, is all ones. Accepts one word per clock.
// Assumes upstream packs bytes into words and marks first/last words.
module ocsum_frame_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_in,
    input  logic         word_valid,
    input  logic         frame_first,
    input  logic         frame_last,
    input  logic         check_mode,
    output logic [W-1:0] sum_word,
    output logic         sum_valid,
    output logic         sum_ok
);
    logic                take;
    logic                restart;
    logic                close;
    logic [W-1:0]        sum_now;
    ocsum_pkg::sum_mode_e mode;

    // Qualify markers and mode with the valid strobe.
    always_comb begin
        take    = word_valid;
        restart = word_valid && frame_first;
        close   = word_valid && frame_last;
        mode    = check_mode ? ocsum_pkg::SUM_CHECK : ocsum_pkg::SUM_GENERATE;
    end

    ocsum_accum #(.W(W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .restart (restart),
        .word    (word_in),
        .sum_now (sum_now)
    );

    ocsum_report #(.W(W)) u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .close     (close),
        .mode      (mode),
        .sum_now   (sum_now),
        .sum_word  (sum_word),
        .sum_valid (sum_valid),
        .sum_ok    (sum_ok)
    );
endmodule

// File: rtl/ocsum_frame_unit_chk.sv
// Module: ocsum_frame_unit_chk
// Protocol and result checks on the checksum unit's ports, bound to it.
// Assumes reset is held for at least one clock before first use.
module ocsum_frame_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         word_valid,
    input logic         frame_last,
    input logic         check_mode,
    input logic [W-1:0] sum_word,
    input logic         sum_valid,
    input logic         sum_ok
);
    logic armed;

    // Becomes 1 one cycle after reset is released, so $past is defined.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!sum_valid && !sum_ok && sum_word == '0));

    // R5
    strobe_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && frame_last) |=> sum_valid);

    // R5
    strobe_only_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sum_valid) |-> $past(word_valid && frame_last));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(word_valid && frame_last)) |-> ($stable(sum_word) && $stable(sum_ok)));

    // R7
    gen_no_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sum_valid && !$past(check_mode)) |-> !sum_ok);

    // R7
    ok_means_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sum_valid && $past(check_mode)) |-> (sum_ok == (sum_word == '0)));
endmodule

bind ocsum_frame_unit ocsum_frame_unit_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .frame_last (frame_last),
    .check_mode (check_mode),
    .sum_word   (sum_word),
    .sum_valid  (sum_valid),
    .sum_ok     (sum_ok)
);

// File: tb/ocsum_frame_unit_test.sv
// Bench: sweeps single- and two-word frames, then runs longer frames with
// gaps, restarts and check-mode verification. Expected values are computed
// by summing in 32 bits and folding the carries at the end.
module ocsum_frame_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] word_in = '0;
    logic        word_valid = 1'b0;
    logic        frame_first = 1'b0;
    logic        frame_last = 1'b0;
    logic        check_mode = 1'b0;
    logic [15:0] sum_word;
    logic        sum_valid;
    logic        sum_ok;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] fr [0:15];

    always #5 clk = ~clk;

    ocsum_frame_unit uut (
        .clk (clk), .rst_n (rst_n), .word_in (word_in), .word_valid (word_valid),
        .frame_first (frame_first), .frame_last (frame_last), .check_mode (check_mode),
        .sum_word (sum_word), .sum_valid (sum_valid), .sum_ok (sum_ok)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fold(input int n);
        logic [31:0] s = 32'd0;
        for (int i = 0; i < n; i++) s = s + {16'd0, fr[i]};
        while (s[31:16] != 16'd0) s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
        return s[15:0];
    endfunction

    // Drive a frame of n words from fr; optional idle gaps carrying junk.
    task automatic run_frame(input int n, input bit chk, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 2 == 1)) begin
                word_valid = 1'b0; word_in = 16'hDEAD;
                frame_first = 1'b1; frame_last = 1'b1; check_mode = ~chk;
                @(negedge clk);
            end
            word_valid = 1'b1; word_in = fr[i];
            frame_first = (i == 0); frame_last = (i == n - 1); check_mode = chk;
            @(negedge clk);
        end
        word_valid = 1'b0; frame_first = 1'b0; frame_last = 1'b0; word_in = 16'h5A5A;
    endtask

    // Check strobe, value and flag for a finished frame; then strobe drop.
    task automatic expect_result(input int n, input bit chk, input string req);
        logic [15:0] s;
        logic [15:0] exp_w;
        bit exp_ok;
        s = fold(n);
        exp_w = ~s;
        exp_ok = chk && (s == 16'hFFFF);
        check(sum_valid == 1'b1, "R5 strobe", {31'd0, sum_valid}, 32'd1);
        check(sum_word == exp_w, req, {16'd0, sum_word}, {16'd0, exp_w});
        check(sum_ok == exp_ok, "R7 flag", {31'd0, sum_ok}, {31'd0, exp_ok});
        @(negedge clk);
        if (sum_valid) check(1'b0, "R5 one-cycle strobe", 32'd1, 32'd0);
        if (sum_word != exp_w) check(1'b0, "R6 hold", {16'd0, sum_word}, {16'd0, exp_w});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sum_valid == 1'b0 && sum_ok == 1'b0 && sum_word == 16'h0000, "R1 reset",
              {sum_valid, sum_ok, 14'd0, sum_word}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9, R5: single-word frames across the word range.
        for (int v = 0; v < 65536; v += 257) begin
            fr[0] = v[15:0];
            run_frame(1, 1'b0, 1'b0);
            expect_result(1, 1'b0, "R9 single word");
        end
        fr[0] = 16'hFFFF; run_frame(1, 1'b0, 1'b0); expect_result(1, 1'b0, "R9 all ones word");

        // R3: explicit end-around carry case, then a two-word grid.
        fr[0] = 16'hFFFF; fr[1] = 16'h0001;
        run_frame(2, 1'b0, 1'b0);
        check(sum_word == 16'hFFFE, "R3 FFFF+0001", {16'd0, sum_word}, 32'h0000FFFE);
        @(negedge clk);
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                fr[0] = 16'(a * 2113 + 16'h8000 * (a % 2));
                fr[1] = 16'(b * 4099 + 16'hC001 * (b % 3));
                run_frame(2, 1'b0, 1'b0);
                expect_result(2, 1'b0, "R3 two-word sum");
            end
        end

        // R8: all-zero frame: check value FFFF, never verifies.
        for (int i = 0; i < 4; i++) fr[i] = 16'h0000;
        run_frame(4, 1'b0, 1'b0); expect_result(4, 1'b0, "R8 zero frame value");
        run_frame(4, 1'b1, 1'b0);
        check(sum_ok == 1'b0, "R8 zero frame not verified", {31'd0, sum_ok}, 32'd0);
        @(negedge clk);

        // R4, R5, R7: long frames with gaps, then check mode with appended word.
        for (int k = 0; k < 40; k++) begin
            int n = 3 + (k % 10);
            for (int i = 0; i < n; i++) fr[i] = 16'((k + 1) * 40503 + i * 9973 + (i * i * 771));
            run_frame(n, 1'b0, k[0]);
            expect_result(n, 1'b0, "R4 gapped frame");
            fr[n] = ~fold(n);
            run_frame(n + 1, 1'b1, k[1]);
            check(sum_ok == 1'b1 && sum_word == 16'h0000, "R7 verify good",
                  {15'd0, sum_ok, sum_word}, 32'h00010000);
            @(negedge clk);
            fr[k % n] = fr[k % n] ^ 16'h0100;
            run_frame(n + 1, 1'b1, 1'b0);
            expect_result(n + 1, 1'b1, "R7 verify corrupted");
        end

        // R2: abandoned frame cut off by a new start.
        word_valid = 1'b1; frame_first = 1'b1; frame_last = 1'b0; word_in = 16'h1234;
        @(negedge clk);
        word_in = 16'hABCD; frame_first = 1'b0;
        @(negedge clk);
        fr[0] = 16'h0F0F; fr[1] = 16'h7001; fr[2] = 16'h8888;
        run_frame(3, 1'b0, 1'b0);
        expect_result(3, 1'b0, "R2 restart discards old sum");

        // R6: result holds over idle cycles with junk inputs.
        word_valid = 1'b0; word_in = 16'hFFFF; frame_last = 1'b1;
        repeat (5) @(negedge clk);
        check(sum_word == ~fold(3) && sum_valid == 1'b0, "R6 hold while idle",
              {15'd0, sum_valid, sum_word}, {16'd0, ~fold(3)});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule